// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block is the clocked control core for a full bridge built from two half-bridges, A and B. Each half takes a low-side and a high-side command and produces a low-side and a high-side gate enable. One shared off input overrides every command. Inside each half the low-side command wins over the high-side command. Each turn-on waits a programmable number of clock cycles, and the opposite switch of the half must already be off before that wait starts. Turn-offs are not delayed.

When the off input is released, both low-side gates give a refresh pulse of programmable width. The high sides stay blocked for a longer programmable wait. If a half's high-side command is tied high, the low-side command alone moves that half between its two switches in complementary fashion. The commands and the off input each pass through a two-flop synchroniser. The four timing counts are captured into registers on every clock. After reset the block behaves as if the off input were asserted.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: During reset and after it, all four gate outputs are low, and the off state holds until the off input has been seen low.
- R2: The off input high drives all four gates low three clock edges after it is applied (two synchroniser stages and one register), whatever the commands are.
- R3: In a half whose low-side command is high, the high-side gate is off, whatever that half's high-side command is.
- R4: With the off input low, the low-side command low and the high-side command high, only the high-side gate of that half is on. With both commands low, both gates of that half are off.
- R5: A gate turns off three edges after its command drops, with no dead time added.
- R6: A gate turns on 3 + D edges after its command rises when the opposite gate is already off. D is the dead_hi count for high-side gates and the dead_lo count for low-side gates, and both halves share these counts. When the opposite gate was on, the turn-on comes 4 + D edges after the command change.
- R7: A half whose high-side command is held high is complementary: the low-side command high gives only the low gate on, and low gives only the high gate on, with the dead time at each changeover.
- R8: When the off input falls, both low gates go high 3 edges later and stay high for refresh_len cycles, with the high gates off.
- R9: After the off input falls, no high gate turns on earlier than 4 + hi_wait_len + dead_hi edges later.
- R10: A command withdrawn before its turn-on delay has expired gives no gate pulse, and the delay restarts in full on the next request.
- R11: The low gate and the high gate of one half are never on in the same cycle.
- R12: A command change in one half leaves the gates of the other half unchanged.
- R13: A dead time of zero turns a gate on 3 edges after its command when the opposite gate is off, or 4 edges after when it was on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_lo | input | 2 | Low-side commands, bit 0 half A, bit 1 half B |
| cmd_hi | input | 2 | High-side commands, bit 0 half A, bit 1 half B |
| bridge_off | input | 1 | Shared off request, active high |
| dead_hi | input | CNT_W | High-side turn-on delay in cycles |
| dead_lo | input | CNT_W | Low-side turn-on delay in cycles |
| refresh_len | input | CNT_W | Width of the low-side refresh pulse in cycles |
| hi_wait_len | input | CNT_W | Cycles from release until the high sides may turn on; must exceed refresh_len |
| gate_lo | output | 2 | Low-side gate enables, bit 0 half A, bit 1 half B |
| gate_hi | output | 2 | High-side gate enables, bit 0 half A, bit 1 half B |

## Verification
In a complementary changeover, the turn-off of one switch and the pending turn-on of the other fall in the same synchronised cycle. The bench provokes this by toggling the low-side command while the high-side command is held. It judges the result by checking that the departing gate drops at edge 3, that the arriving gate waits one more interlock cycle plus its dead time, and by checking every cycle that no half has both gates high. Release from off also brings the refresh pulse and the high-side wait into the same window. There the bench checks that the high gates stay low through the pulse and rise only on the computed edge.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
    localparam int unsigned HALVES = 2;

    typedef enum logic [1:0] {
        SEQ_OFF  = 2'd0,
        SEQ_WAKE = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic lo;
        logic hi;
    } leg_pair_t;

    function automatic logic count_done(input logic [15:0] cnt, input logic [15:0] lim);
        return cnt >= lim;
    endfunction
endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
    parameter int unsigned W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbg_seq.sv
module hbg_seq
    import hbg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             off_s,
    input  logic [CNT_W-1:0] refresh_len,
    input  logic [CNT_W-1:0] hi_wait_len,
    output logic             refresh_q,
    output logic             hi_allow
);
    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_nxt;

    assign cnt_nxt  = {1'b0, cnt} + 1'b1;
    assign hi_allow = (state == SEQ_RUN) && !off_s;

    always_ff @(posedge clk) begin
        if (rst || off_s) begin
            state     <= SEQ_OFF;
            cnt       <= '0;
            refresh_q <= 1'b0;
        end else begin
            case (state)
                SEQ_OFF: begin
                    state     <= SEQ_WAKE;
                    cnt       <= '0;
                    refresh_q <= (refresh_len != '0);
                end
                SEQ_WAKE: begin
                    cnt       <= cnt_nxt[CNT_W-1:0];
                    refresh_q <= cnt_nxt < {1'b0, refresh_len};
                    if (cnt_nxt >= {1'b0, hi_wait_len})
                        state <= SEQ_RUN;
                end
                default: begin
                    state     <= SEQ_RUN;
                    refresh_q <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/hbg_leg.sv
module hbg_leg #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             opp_on,
    input  logic [CNT_W-1:0] dly,
    output logic             on_q
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            on_q <= 1'b0;
            cnt  <= '0;
        end else if (on_q) begin
            on_q <= 1'b1;
        end else if (opp_on) begin
            cnt <= '0;
        end else if (cnt >= dly) begin
            on_q <= 1'b1;
            cnt  <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/hbg_half.sv
module hbg_half
    import hbg_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  leg_pair_t        cmd,
    input  logic             off_s,
    input  logic             hi_allow,
    input  logic             refresh,
    input  logic [CNT_W-1:0] dly_lo,
    input  logic [CNT_W-1:0] dly_hi,
    output leg_pair_t        gate
);
    logic lo_req, hi_req, lo_on, hi_on, lo_gate;

    assign lo_req  = cmd.lo && !off_s;
    assign hi_req  = cmd.hi && !cmd.lo && hi_allow;
    assign lo_gate = lo_on || refresh;

    hbg_leg #(.CNT_W(CNT_W)) u_lo (
        .clk(clk), .rst(rst), .req(lo_req), .opp_on(hi_on), .dly(dly_lo), .on_q(lo_on)
    );

    hbg_leg #(.CNT_W(CNT_W)) u_hi (
        .clk(clk), .rst(rst), .req(hi_req), .opp_on(lo_gate), .dly(dly_hi), .on_q(hi_on)
    );

    assign gate.lo = lo_gate;
    assign gate.hi = hi_on;
endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
    import hbg_pkg::*;
#(
    parameter int unsigned CNT_W  = 8,
    parameter int unsigned N_HALF = HALVES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_HALF-1:0] cmd_lo,
    input  logic [N_HALF-1:0] cmd_hi,
    input  logic              bridge_off,
    input  logic [CNT_W-1:0]  dead_hi,
    input  logic [CNT_W-1:0]  dead_lo,
    input  logic [CNT_W-1:0]  refresh_len,
    input  logic [CNT_W-1:0]  hi_wait_len,
    output logic [N_HALF-1:0] gate_lo,
    output logic [N_HALF-1:0] gate_hi
);
    localparam int unsigned CMD_W = 2 * N_HALF;

    logic [N_HALF-1:0] cmd_lo_s, cmd_hi_s;
    logic              off_s;
    logic              refresh_q, hi_allow;
    logic [CNT_W-1:0]  dead_hi_q, dead_lo_q, refresh_len_q, hi_wait_len_q;

    hbg_sync #(.W(CMD_W), .RST_VAL('0)) u_sync_cmd (
        .clk(clk), .rst(rst), .d({cmd_hi, cmd_lo}), .q({cmd_hi_s, cmd_lo_s})
    );

    hbg_sync #(.W(1), .RST_VAL(1'b1)) u_sync_off (
        .clk(clk), .rst(rst), .d(bridge_off), .q(off_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dead_hi_q     <= '0;
            dead_lo_q     <= '0;
            refresh_len_q <= '0;
            hi_wait_len_q <= '0;
        end else begin
            dead_hi_q     <= dead_hi;
            dead_lo_q     <= dead_lo;
            refresh_len_q <= refresh_len;
            hi_wait_len_q <= hi_wait_len;
        end
    end

    hbg_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .off_s(off_s),
        .refresh_len(refresh_len_q), .hi_wait_len(hi_wait_len_q),
        .refresh_q(refresh_q), .hi_allow(hi_allow)
    );

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        leg_pair_t cmd_h, gate_h;
        assign cmd_h.lo = cmd_lo_s[h];
        assign cmd_h.hi = cmd_hi_s[h];

        hbg_half #(.CNT_W(CNT_W)) u_half (
            .clk(clk), .rst(rst), .cmd(cmd_h), .off_s(off_s),
            .hi_allow(hi_allow), .refresh(refresh_q),
            .dly_lo(dead_lo_q), .dly_hi(dead_hi_q), .gate(gate_h)
        );

        assign gate_lo[h] = gate_h.lo;
        assign gate_hi[h] = gate_h.hi;
    end
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
    parameter int unsigned N_HALF = 2
) (
    input logic              clk,
    input logic              rst,
    input logic [N_HALF-1:0] gate_lo,
    input logic [N_HALF-1:0] gate_hi,
    input logic [N_HALF-1:0] cmd_lo_s,
    input logic [N_HALF-1:0] cmd_hi_s,
    input logic              off_s,
    input logic              hi_allow
);
    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        off_s |=> (gate_lo == '0 && gate_hi == '0)); // R2

    for (genvar h = 0; h < N_HALF; h++) begin : g_chk
        AST_NO_SHOOT: assert property (@(posedge clk) disable iff (rst)
            !(gate_lo[h] && gate_hi[h])); // R11
        AST_LO_PRIO: assert property (@(posedge clk) disable iff (rst)
            cmd_lo_s[h] |=> !gate_hi[h]); // R3
        AST_HI_DROP: assert property (@(posedge clk) disable iff (rst)
            !cmd_hi_s[h] |=> !gate_hi[h]); // R5
        AST_HI_WAIT: assert property (@(posedge clk) disable iff (rst)
            $rose(gate_hi[h]) |-> $past(hi_allow)); // R9
    end
endmodule

bind hbridge_gate_ctrl hbg_checker #(.N_HALF(N_HALF)) u_chk (
    .clk(clk), .rst(rst), .gate_lo(gate_lo), .gate_hi(gate_hi),
    .cmd_lo_s(cmd_lo_s), .cmd_hi_s(cmd_hi_s), .off_s(off_s), .hi_allow(hi_allow)
);

// File: tb/sim_hbridge_gate_ctrl.sv
module sim_hbridge_gate_ctrl;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    cmd_lo = 2'b00, cmd_hi = 2'b00;
    logic          bridge_off = 1'b1;
    logic [CW-1:0] dead_hi = 8'd3, dead_lo = 8'd2, refresh_len = 8'd4, hi_wait_len = 8'd8;
    logic [1:0]    gate_lo, gate_hi;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit running = 1'b0;

    typedef struct {
        int         at;
        logic [3:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb[$];

    hbridge_gate_ctrl #(.CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .bridge_off(bridge_off),
        .dead_hi(dead_hi), .dead_lo(dead_lo), .refresh_len(refresh_len),
        .hi_wait_len(hi_wait_len), .gate_lo(gate_lo), .gate_hi(gate_hi)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // vector layout: [3]=hi B, [2]=hi A, [1]=lo B, [0]=lo A
    always @(negedge clk) begin
        if (running) begin
            checks++;
            if ((gate_lo & gate_hi) != 2'b00) begin
                fails++;
                $display("FAIL R11 cycle %0d overlap lo=%b hi=%b expected no common bit", cyc, gate_lo, gate_hi);
            end
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                sb_item_t it;
                it = sb.pop_front();
                checks++;
                if (it.at != cyc || {gate_hi, gate_lo} != it.exp) begin
                    fails++;
                    $display("FAIL %s cycle %0d actual %b expected %b", it.tag, cyc, {gate_hi, gate_lo}, it.exp);
                end
            end
        end
    end

    task automatic drive(input logic [1:0] lo, input logic [1:0] hi, input logic off, output int base);
        @(negedge clk);
        cmd_lo = lo;
        cmd_hi = hi;
        bridge_off = off;
        base = cyc;
    endtask

    task automatic expect_at(input int at, input logic [3:0] v, input string tag);
        sb.push_back('{at, v, tag});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic direct(input logic [3:0] v, input string tag);
        checks++;
        if ({gate_hi, gate_lo} != v) begin
            fails++;
            $display("FAIL %s actual %b expected %b", tag, {gate_hi, gate_lo}, v);
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int c, c2;
        idle(4);
        direct(4'b0000, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
        cmd_hi = 2'b11;
        running = 1'b1;
        idle(6);
        direct(4'b0000, "R1 off after reset");

        // release: refresh pulse and high-side wait (R8, R9)
        drive(2'b00, 2'b11, 1'b0, c);
        expect_at(c + 2, 4'b0000, "R8 before pulse");
        expect_at(c + 3, 4'b0011, "R8 pulse start");
        expect_at(c + 6, 4'b0011, "R8 pulse last");
        expect_at(c + 7, 4'b0000, "R8 pulse end");
        expect_at(c + 14, 4'b0000, "R9 high still blocked");
        expect_at(c + 15, 4'b1100, "R9 high enabled R4");
        idle(20);

        // low priority and complementary mode on half A (R3, R6, R7, R12)
        drive(2'b01, 2'b11, 1'b0, c);
        expect_at(c + 2, 4'b1100, "R3 before");
        expect_at(c + 3, 4'b1000, "R3 high A off R12");
        expect_at(c + 5, 4'b1000, "R6 low A waiting");
        expect_at(c + 6, 4'b1001, "R7 low A on");
        idle(10);

        drive(2'b00, 2'b11, 1'b0, c);
        expect_at(c + 2, 4'b1001, "R5 before");
        expect_at(c + 3, 4'b1000, "R5 low A off");
        expect_at(c + 6, 4'b1000, "R6 high A waiting");
        expect_at(c + 7, 4'b1100, "R7 high A back");
        idle(10);

        // both commands low on B (R4, R5)
        drive(2'b00, 2'b01, 1'b0, c);
        expect_at(c + 2, 4'b1100, "R5 before B");
        expect_at(c + 3, 4'b0100, "R4 B both off");
        idle(8);

        // low B from idle, opposite off (R6)
        drive(2'b10, 2'b01, 1'b0, c);
        expect_at(c + 4, 4'b0100, "R6 low B waiting");
        expect_at(c + 5, 4'b0110, "R6 low B on");
        idle(8);

        drive(2'b00, 2'b01, 1'b0, c);
        expect_at(c + 3, 4'b0100, "R5 low B off");
        idle(8);

        // cancelled pending turn-on, then full restart (R10)
        drive(2'b10, 2'b01, 1'b0, c2);
        idle(1);
        drive(2'b00, 2'b01, 1'b0, c);
        expect_at(c2 + 3, 4'b0100, "R10 no pulse a");
        expect_at(c2 + 5, 4'b0100, "R10 no pulse b");
        expect_at(c2 + 7, 4'b0100, "R10 no pulse c");
        idle(10);
        drive(2'b10, 2'b01, 1'b0, c);
        expect_at(c + 4, 4'b0100, "R10 restart waiting");
        expect_at(c + 5, 4'b0110, "R10 restart on");
        idle(8);

        // off while running (R2)
        drive(2'b10, 2'b01, 1'b1, c);
        expect_at(c + 2, 4'b0110, "R2 before");
        expect_at(c + 3, 4'b0000, "R2 all off");
        expect_at(c + 6, 4'b0000, "R2 stays off");
        idle(8);

        // zero counts (R13)
        @(negedge clk);
        dead_hi = 8'd0;
        dead_lo = 8'd0;
        idle(3);
        drive(2'b00, 2'b11, 1'b0, c);
        expect_at(c + 3, 4'b0011, "R8 pulse zero dt");
        expect_at(c + 7, 4'b0000, "R8 pulse end zero dt");
        expect_at(c + 11, 4'b0000, "R9 blocked zero dt");
        expect_at(c + 12, 4'b1100, "R13 high immediate");
        idle(16);
        drive(2'b01, 2'b11, 1'b0, c);
        expect_at(c + 3, 4'b1000, "R13 high A off");
        expect_at(c + 4, 4'b1001, "R13 low A after interlock");
        idle(8);
        drive(2'b11, 2'b11, 1'b0, c);
        expect_at(c + 3, 4'b0001, "R13 high B off");
        expect_at(c + 4, 4'b0011, "R13 low B on");
        idle(8);

        wait (sb.size() == 0);
        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule